// File: doc/BRIEF.md
# Thermometer-Code Switched-Capacitor Frequency Integrator

This block is the digital integrator that steers a divide-by-two switched-capacitor supply. It keeps a thermometer code in a shift register. Two comparator flags describe where the supply sits relative to a reference: one says it is under the lower threshold, the other says it is over the upper threshold. When only the low flag is set, the code gains a one. When only the high flag is set, it loses a one. Between the two thresholds the code stays put, so it does not dither around the reference.

The number of ones in the code is the binary period select for the switching oscillator, from 0 (slowest) to 7 (fastest). The same select turns on wider switch segments as the frequency rises. A warmup input forces the fastest setting, and with it every segment, without changing the stored code. The integrator updates at a rate that follows the selected frequency: at high settings it updates more often, and at low settings it waits longer between updates. All pins are plain control and status levels, so there is no stream handshake and no back-pressure.

Top module: `sc_freq_integrator`

## Requirements
- R1: Reset (active-low `rst_n`) loads the code with its three lowest bits set (7'b0000111). This gives `period_sel` = 3, and update step time is reached on the first enabled cycle.
- R2: On an update step with `below_lo`=1 and `above_hi`=0, the code shifts left with a 1 entering bit 0, which adds one more set bit.
- R3: On an update step with `above_hi`=1 and `below_lo`=0, the code shifts right with a 0 entering the top bit, which removes one set bit.
- R4: On an update step where both flags are 0, or both are 1, the code does not change.
- R5: The code saturates at 7'b1111111 and at 7'b0000000, and its set bits always form one contiguous run starting at bit 0.
- R6: `period_sel` equals the number of ones in the code. While `warmup`=1 it is 7, and the code is not affected.
- R7: `seg_en[k]` is 1 exactly when `period_sel` >= 3*k. This makes bit 0 always on, bit 1 on from select 3, and bit 2 on from select 6.
- R8: After an update step taken with effective select S, the next update step comes 8-S enabled cycles later. With `warmup`=1 this means every enabled cycle.
- R9: While `en`=0 the code and the update timing are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Integrator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables updates and update timing |
| below_lo | input | 1 | Supply is under the lower comparator threshold |
| above_hi | input | 1 | Supply is over the upper comparator threshold |
| warmup | input | 1 | Forces the fastest setting and all segments |
| therm | output | 7 | Thermometer code |
| period_sel | output | 3 | Binary oscillator period select (count of ones) |
| seg_en | output | 3 | Switch-segment enables |

## Verification
The code is driven upward with the low flag held until it saturates, then downward with the high flag held until it empties. This separates the shift direction and the fill bit, and it shows whether each end saturates correctly. The in-band case and the both-flags case are run from several code levels, to tell a true hold apart from a stray shift. The bench toggles warmup in the middle of a ramp. This shows whether the select override disturbs the stored code, and it shows the shortened update interval. Stretches with enable low, placed while an update is pending, show whether the interval counter freezes or slips.

// File: rtl/scfi_pkg.sv
package scfi_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2
  } scfi_act_t;
endpackage

// File: rtl/scfi_code_reg.sv
module scfi_code_reg
  import scfi_pkg::*;
#(
  parameter int W       = 7,
  parameter int RST_LVL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  scfi_act_t       act,
  output logic [W-1:0]    code
);
  localparam logic [W-1:0] RST_PAT = {W{1'b1}} >> (W - RST_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= RST_PAT;
    end else if (step) begin
      case (act)
        ACT_UP:   code <= {code[W-2:0], 1'b1};
        ACT_DOWN: code <= {1'b0, code[W-1:1]};
        default:  code <= code;
      endcase
    end
  end

  // R5: one contiguous run of ones from bit 0
  a_r5_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ((code & (code + 1'b1)) == '0));
  a_r5_top_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act == ACT_UP && (&code)) |=> (&code));
  a_r5_bottom_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act == ACT_DOWN && code == '0) |=> (code == '0));
  a_r2_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act == ACT_UP && !code[W-1]) |=>
      ($countones(code) == $countones($past(code)) + 1));
  a_r3_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act == ACT_DOWN && code[0]) |=>
      ($countones(code) + 1 == $countones($past(code))));
  a_r4_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act == ACT_HOLD) |=> $stable(code));
endmodule

// File: rtl/scfi_rate_div.sv
module scfi_rate_div #(
  parameter int MAXL = 7,
  parameter int SW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] eff_sel,
  output logic          step
);
  logic [SW-1:0] cnt;

  assign step = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= SW'(MAXL) - eff_sel;
    end else if (en) begin
      cnt <= cnt - 1'b1;
    end
  end

  a_r8_span: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) <= MAXL));
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> (cnt + 1'b1 == $past(cnt)));
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(cnt));
endmodule

// File: rtl/scfi_seg_dec.sv
module scfi_seg_dec #(
  parameter int W        = 7,
  parameter int SW       = 3,
  parameter int SEG_N    = 3,
  parameter int SEG_STEP = 3
) (
  input  logic [W-1:0]     code,
  input  logic             warmup,
  output logic [SW-1:0]    sel,
  output logic [SEG_N-1:0] seg_en
);
  logic [SW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + SW'(code[i]);
  end

  assign sel = warmup ? SW'(W) : ones;

  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign seg_en[k] = (int'(sel) >= k * SEG_STEP);
  end
endmodule

// File: rtl/sc_freq_integrator.sv
module sc_freq_integrator
  import scfi_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int RST_LVL  = 3,
  parameter int SEG_N    = 3,
  parameter int SEG_STEP = 3,
  localparam int SW      = $clog2(CODE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             below_lo,
  input  logic             above_hi,
  input  logic             warmup,
  output logic [CODE_W-1:0] therm,
  output logic [SW-1:0]     period_sel,
  output logic [SEG_N-1:0]  seg_en
);
  scfi_act_t act;
  logic      step;

  always_comb begin
    if (below_lo && !above_hi)      act = ACT_UP;
    else if (above_hi && !below_lo) act = ACT_DOWN;
    else                            act = ACT_HOLD;
  end

  scfi_code_reg #(.W(CODE_W), .RST_LVL(RST_LVL)) u_code (
    .clk(clk), .rst_n(rst_n), .step(step), .act(act), .code(therm)
  );

  scfi_rate_div #(.MAXL(CODE_W), .SW(SW)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(en), .eff_sel(period_sel), .step(step)
  );

  scfi_seg_dec #(.W(CODE_W), .SW(SW), .SEG_N(SEG_N), .SEG_STEP(SEG_STEP)) u_seg (
    .code(therm), .warmup(warmup), .sel(period_sel), .seg_en(seg_en)
  );

  a_r6_warm_max: assert property (@(posedge clk) disable iff (!rst_n)
    warmup |-> (int'(period_sel) == CODE_W && (&seg_en)));
  a_r6_warm_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (warmup && !below_lo && !above_hi) |=> $stable(therm));
  a_r7_seg_base: assert property (@(posedge clk) disable iff (!rst_n)
    seg_en[0]);
  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(therm));
endmodule

// File: tb/sc_freq_integrator_bench.sv
module sc_freq_integrator_bench;
  localparam int W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, below_lo = 1'b0, above_hi = 1'b0, warmup = 1'b0;
  logic [W-1:0] therm;
  logic [2:0]   period_sel;
  logic [2:0]   seg_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  int m_lvl;
  int m_wait;

  always #2 clk = ~clk;

  sc_freq_integrator u_sc_freq_integrator (
    .clk(clk), .rst_n(rst_n), .en(en), .below_lo(below_lo),
    .above_hi(above_hi), .warmup(warmup),
    .therm(therm), .period_sel(period_sel), .seg_en(seg_en)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One enabled-or-not cycle: drive, compare model outputs, advance model.
  task automatic cycle(input string tag, input logic e, input logic lo,
                       input logic hi, input logic wu);
    int sel;
    int seg;
    @(negedge clk);
    en = e; below_lo = lo; above_hi = hi; warmup = wu;
    #1;
    sel = wu ? W : m_lvl;
    seg = 0;
    for (int k = 0; k < 3; k++) if (sel >= 3 * k) seg |= (1 << k);
    chk({tag, " therm"}, int'(therm), (1 << m_lvl) - 1);
    chk({tag, " period_sel R6"}, int'(period_sel), sel);
    chk({tag, " seg_en R7"}, int'(seg_en), seg);
    @(posedge clk);
    if (e) begin
      if (m_wait == 0) begin
        if (lo && !hi && m_lvl < W) m_lvl++;
        else if (hi && !lo && m_lvl > 0) m_lvl--;
        m_wait = W - sel;
      end else begin
        m_wait--;
      end
    end
  endtask

  initial begin
    m_lvl = 3;
    m_wait = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset pattern, select and segments
    @(negedge clk); #1;
    chk("R1 reset therm", int'(therm), 7);
    chk("R1 reset period_sel", int'(period_sel), 3);
    chk("R1 reset seg_en", int'(seg_en), 3);
    // R4: band hold and both-flags hold at mid level
    for (int i = 0; i < 10; i++) cycle("R4 band", 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) cycle("R4 both", 1, 1, 1, 0);
    // R2/R8: ramp up with cadence following select, into saturation R5
    for (int i = 0; i < 40; i++) cycle("R2 R8 up", 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) cycle("R5 top sat", 1, 1, 0, 0);
    chk("R5 full code", int'(therm), 127);
    // R4 at top
    for (int i = 0; i < 6; i++) cycle("R4 top band", 1, 0, 0, 0);
    // R3/R8: ramp down into empty code R5
    for (int i = 0; i < 60; i++) cycle("R3 R8 down", 1, 0, 1, 0);
    for (int i = 0; i < 10; i++) cycle("R5 bottom sat", 1, 0, 1, 0);
    chk("R5 empty code", int'(therm), 0);
    // R6/R8: warmup forces max select, code untouched in band, fast cadence
    for (int i = 0; i < 6; i++) cycle("R6 warm band", 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) cycle("R6 R8 warm up", 1, 1, 0, 1);
    for (int i = 0; i < 5; i++) cycle("R7 after warm", 1, 1, 0, 0);
    // R9: enable low freezes code and pending interval
    for (int i = 0; i < 12; i++) cycle("R9 frozen", 0, 1, 0, 0);
    for (int i = 0; i < 20; i++) cycle("R9 resume", 1, 1, 0, 0);
    for (int i = 0; i < 7; i++) cycle("R9 frozen down", 0, 0, 1, 1);
    // mixed pattern
    for (int i = 0; i < 60; i++)
      cycle("R2 R3 R4 mix", 1, (i % 7) < 3, (i % 5) == 0, (i % 11) == 4);
    finish_run();
  end
endmodule